// File: doc/BRIEF.md
# LL/SC Reservation Monitor

This block sits in front of a small word-addressed memory that several cores share. It makes load-linked and store-conditional available to them. Each core presents plain loads, plain stores, load-linked and store-conditional requests on its own lane of the request inputs. A round-robin arbiter serves one request per cycle. The monitor keeps a single reservation per core: a valid flag and a word address. It uses that reservation to decide whether a store-conditional may write. A failed store-conditional leaves memory untouched and returns status 0. A successful one writes and returns 1.

Software builds its locks and counters on top of this. A lock word of 0 means free and 1 means held. Acquiring spins on load-linked until it reads 0, then tries a store-conditional of 1, and starts again from the load-linked whenever that returns 0. Releasing is a plain store of 0, and that store also breaks any reservation held on the lock word.

The control is a two-state machine. After reset it is in `ST_CLEAR` and sweeps every memory word to zero, one word per cycle, granting nothing. On the cycle it clears the last word it takes the transition `CLEAR_DONE` to `ST_SERVE`. It stays in `ST_SERVE` (transition `SERVE_HOLD`) until the next reset. Each granted request updates memory and the reservation table at the clock edge that ends its grant cycle. A registered response carrying the requesting core's ID is visible in the following cycle.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset the block clears all DEPTH words to zero and grants nothing for exactly DEPTH cycles. A request held from reset release is first granted in the cycle after the DEPTH-th rising edge.
- R2: The opcode encoding is LOAD=0, STORE=1, LL=2, SC=3. A request granted in cycle t gets a response in cycle t+1: `rsp_valid`=1, `rsp_core` set to the granted core, and `rsp_rdata` equal to the memory word for LOAD and LL, or 0 for STORE and SC. A STORE always writes its data.
- R3: An LL returns the current word and reserves its address for the issuing core. A later SC from that core to that address, with no store to the address in between, writes its data and returns `rsp_sc_ok`=1.
- R4: A STORE from another core to a reserved address, issued between the LL and the SC, makes the SC fail: status 0, memory unchanged.
- R5: An SC from a core with no valid reservation, or whose reservation names a different address, fails with status 0 and does not write.
- R6: A core's own SC clears its reservation whether it succeeds or fails, so a second SC without a new LL fails.
- R7: Any write (a STORE or a successful SC) to an address clears every reservation on that address, including the writer's own.
- R8: A core holds one reservation only. A second LL to another address replaces the first, after which an SC to the first address fails.
- R9: At most one core is granted per cycle, and only a core that is requesting. When all cores request together, they are served on consecutive cycles in cyclic core order.
- R10: When two cores hold reservations on the same word and issue SCs together, the SC granted first succeeds and the other fails. Memory holds the winner's data.
- R11: A spin lock built from LL/SC never lets two cores into the critical section at once. Concurrent LL/SC increments from all cores lose no update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CORES | Per-core request pending, held until granted |
| req_op | input | 2*N_CORES | Per-core opcode, lane c at bits [2c+1:2c] |
| req_addr | input | AW*N_CORES | Per-core word address, AW = log2(DEPTH) |
| req_wdata | input | DW*N_CORES | Per-core write data for STORE and SC |
| req_gnt | output | N_CORES | One-hot grant; the request is taken at the coming edge |
| rsp_valid | output | 1 | Response present |
| rsp_core | output | IW | Core the response belongs to |
| rsp_rdata | output | DW | Read data for LOAD and LL, zero otherwise |
| rsp_sc_ok | output | 1 | 1 when the answered request was a successful SC |

## Verification
If a reservation is wrongly valid or wrongly cleared, the block shows it at the first SC from that core. The status in the cycle after the SC's grant comes out inverted, and a LOAD of the word afterwards reads the wrong value. A fault in the arbiter pointer shows up as out-of-order or duplicated grants within one round of simultaneous requests. A fault in the sweep changes the cycle of the first grant, or lets a nonzero word be read back after reset. Lost lock or increment updates show up only as a short final count once all workers have finished.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } mem_op_e;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_SERVE = 1'b1
    } mon_state_e;

endpackage

// File: rtl/llsc_rr_arb.sv
module llsc_rr_arb #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] last_q;
    logic [IW-1:0] cand;
    logic          found;

    // search starts at the core after the last one served
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = '0;
        for (int off = 1; off <= N; off++) begin
            cand = IW'((int'(last_q) + off) % N);
            if (en && !found && req[cand]) begin
                found        = 1'b1;
                gnt[cand]    = 1'b1;
                gnt_idx      = cand;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (found) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/llsc_resv_tab.sv
module llsc_resv_tab
    import llsc_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic [IW-1:0] acc_core,
    input  mem_op_e       acc_op,
    input  logic [AW-1:0] acc_addr,
    output logic          sc_pass,
    output logic          wr_en,
    output logic [N-1:0]  resv_vld
);

    logic [AW-1:0] resv_addr_q [N];

    assign sc_pass = acc_en && (acc_op == OP_SC) && resv_vld[acc_core]
                     && (resv_addr_q[acc_core] == acc_addr);
    assign wr_en   = acc_en && ((acc_op == OP_STORE) || sc_pass);

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic own;
        assign own = (acc_core == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                resv_vld[g]    <= 1'b0;
                resv_addr_q[g] <= '0;
            end else if (acc_en) begin
                if (own && acc_op == OP_LL) begin
                    resv_vld[g]    <= 1'b1;
                    resv_addr_q[g] <= acc_addr;
                end else if (own && acc_op == OP_SC) begin
                    resv_vld[g] <= 1'b0;
                end
                if (wr_en && resv_addr_q[g] == acc_addr) begin
                    resv_vld[g] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem_q[clr_addr] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
    import llsc_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int DEPTH   = 16,
    parameter int DW      = 32,
    localparam int AW     = $clog2(DEPTH),
    localparam int IW     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_CORES-1:0]    req_valid,
    input  logic [2*N_CORES-1:0]  req_op,
    input  logic [AW*N_CORES-1:0] req_addr,
    input  logic [DW*N_CORES-1:0] req_wdata,
    output logic [N_CORES-1:0]    req_gnt,
    output logic                  rsp_valid,
    output logic [IW-1:0]         rsp_core,
    output logic [DW-1:0]         rsp_rdata,
    output logic                  rsp_sc_ok
);

    mon_state_e    state_q, state_d;
    logic [AW-1:0] clr_idx_q;
    logic          serve_en;
    logic          acc_en;
    logic [IW-1:0] gnt_idx;
    mem_op_e       sel_op;
    logic [AW-1:0] sel_addr;
    logic [DW-1:0] sel_wdata;
    logic          sc_pass;
    logic          wr_en;
    logic [N_CORES-1:0] resv_vld;
    logic [DW-1:0] mem_rdata;
    logic          sel_is_sc;
    logic          sel_resv_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_CLEAR;
            clr_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) begin
                clr_idx_q <= clr_idx_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_idx_q == AW'(DEPTH - 1)) state_d = ST_SERVE;
            ST_SERVE: state_d = ST_SERVE;
            default:  state_d = ST_CLEAR;
        endcase
    end

    assign serve_en = (state_q == ST_SERVE);

    llsc_rr_arb #(.N(N_CORES), .IW(IW)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (serve_en),
        .req     (req_valid),
        .gnt     (req_gnt),
        .gnt_idx (gnt_idx)
    );

    assign acc_en    = |req_gnt;
    assign sel_op    = mem_op_e'(req_op[int'(gnt_idx)*2 +: 2]);
    assign sel_addr  = req_addr[int'(gnt_idx)*AW +: AW];
    assign sel_wdata = req_wdata[int'(gnt_idx)*DW +: DW];

    llsc_resv_tab #(.N(N_CORES), .AW(AW), .IW(IW)) tab_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .acc_core (gnt_idx),
        .acc_op   (sel_op),
        .acc_addr (sel_addr),
        .sc_pass  (sc_pass),
        .wr_en    (wr_en),
        .resv_vld (resv_vld)
    );

    llsc_word_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) mem_i (
        .clk      (clk),
        .clr_en   (!serve_en),
        .clr_addr (clr_idx_q),
        .wr_en    (wr_en),
        .addr     (sel_addr),
        .wdata    (sel_wdata),
        .rdata    (mem_rdata)
    );

    assign sel_is_sc   = acc_en && (sel_op == OP_SC);
    assign sel_resv_ok = resv_vld[gnt_idx];

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_core  <= '0;
            rsp_rdata <= '0;
            rsp_sc_ok <= 1'b0;
        end else begin
            rsp_valid <= acc_en;
            rsp_core  <= gnt_idx;
            rsp_rdata <= (acc_en && (sel_op == OP_LOAD || sel_op == OP_LL))
                         ? mem_rdata : '0;
            rsp_sc_ok <= sc_pass;
        end
    end

endmodule

// File: rtl/llsc_resv_checker.sv
module llsc_resv_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_valid,
    input logic [N-1:0] req_gnt,
    input logic         serve,
    input logic         rsp_valid,
    input logic         rsp_sc_ok,
    input logic         sel_is_sc,
    input logic         sel_resv_ok
);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_gnt)); // R9

    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_gnt & ~req_valid) == '0); // R9

    AST_NO_GNT_CLEARING: assert property (@(posedge clk) disable iff (!rst_n)
        !serve |-> req_gnt == '0); // R1

    AST_RSP_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_gnt) |=> rsp_valid); // R2

    AST_RSP_ONLY_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req_gnt) |=> !rsp_valid); // R2

    AST_SC_OK_NEEDS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_is_sc |=> !rsp_sc_ok); // R3

    AST_SC_NO_RESV_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_is_sc && !sel_resv_ok) |=> !rsp_sc_ok); // R5

endmodule

bind llsc_resv_monitor llsc_resv_checker #(.N(N_CORES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_gnt     (req_gnt),
    .serve       (serve_en),
    .rsp_valid   (rsp_valid),
    .rsp_sc_ok   (rsp_sc_ok),
    .sel_is_sc   (sel_is_sc),
    .sel_resv_ok (sel_resv_ok)
);

// File: tb/llsc_resv_monitor_tb_top.sv
module llsc_resv_monitor_tb_top;

    localparam int NC    = 4;
    localparam int DEPTH = 16;
    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int IW    = 2;

    localparam logic [1:0] LOAD  = 2'd0;
    localparam logic [1:0] STORE = 2'd1;
    localparam logic [1:0] LL    = 2'd2;
    localparam logic [1:0] SC    = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk; // 125 MHz

    logic          v_a   [NC];
    logic [1:0]    op_a  [NC];
    logic [AW-1:0] ad_a  [NC];
    logic [DW-1:0] wd_a  [NC];

    logic [NC-1:0]    req_valid;
    logic [2*NC-1:0]  req_op;
    logic [AW*NC-1:0] req_addr;
    logic [DW*NC-1:0] req_wdata;
    logic [NC-1:0]    req_gnt;
    logic             rsp_valid;
    logic [IW-1:0]    rsp_core;
    logic [DW-1:0]    rsp_rdata;
    logic             rsp_sc_ok;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            req_valid[c]          = v_a[c];
            req_op[c*2 +: 2]      = op_a[c];
            req_addr[c*AW +: AW]  = ad_a[c];
            req_wdata[c*DW +: DW] = wd_a[c];
        end
    end

    llsc_resv_monitor #(.N_CORES(NC), .DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_gnt   (req_gnt),
        .rsp_valid (rsp_valid),
        .rsp_core  (rsp_core),
        .rsp_rdata (rsp_rdata),
        .rsp_sc_ok (rsp_sc_ok)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // issue one request and wait for its response
    task automatic do_req(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd,
                          output logic ok, output int gcyc);
        @(negedge clk);
        op_a[c] = op; ad_a[c] = a; wd_a[c] = d; v_a[c] = 1'b1;
        #1;
        while (!req_gnt[c]) begin
            @(negedge clk);
            #1;
        end
        gcyc = cyc;
        @(negedge clk);
        v_a[c] = 1'b0;
        rd = rsp_rdata;
        ok = rsp_sc_ok;
        chk("R2 response tag", 32'({rsp_valid, rsp_core}), 32'({1'b1, IW'(c)}));
    endtask

    task automatic rq(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd, output logic ok);
        int g;
        do_req(c, op, a, d, rd, ok, g);
    endtask

    task automatic t_reset();
        int cnt = 0;
        logic [DW-1:0] rd;
        logic ok;
        for (int c = 0; c < NC; c++) begin
            v_a[c] = 1'b0; op_a[c] = LOAD; ad_a[c] = '0; wd_a[c] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1 no grant in reset", 32'(req_gnt), 32'd0);
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        op_a[0] = LOAD; ad_a[0] = 4'd3; v_a[0] = 1'b1;
        #1;
        while (!req_gnt[0] && cnt < 100) begin
            @(negedge clk);
            #1;
            cnt++;
        end
        chk("R1 first grant cycle", 32'(cnt), 32'(DEPTH));
        @(negedge clk);
        v_a[0] = 1'b0;
        chk("R1 cleared word 3", rsp_rdata, 32'd0);
        rq(2, LOAD, 4'd15, '0, rd, ok);
        chk("R1 cleared word 15", rd, 32'd0);
    endtask

    task automatic t_load_store();
        logic [DW-1:0] rd;
        logic ok;
        rq(1, STORE, 4'd4, 32'hA5A5_0004, rd, ok);
        chk("R2 store rdata zero", rd, 32'd0);
        rq(2, LOAD, 4'd4, '0, rd, ok);
        chk("R2 load after store", rd, 32'hA5A5_0004);
        chk("R2 load status", 32'(ok), 32'd0);
    endtask

    task automatic t_ll_sc_ok();
        logic [DW-1:0] rd;
        logic ok;
        rq(0, STORE, 4'd6, 32'h66, rd, ok);
        rq(0, LL, 4'd6, '0, rd, ok);
        chk("R3 LL returns word", rd, 32'h66);
        rq(0, SC, 4'd6, 32'h11, rd, ok);
        chk("R3 SC status", 32'(ok), 32'd1);
        rq(3, LOAD, 4'd6, '0, rd, ok);
        chk("R3 SC wrote", rd, 32'h11);
    endtask

    task automatic t_sc_broken();
        logic [DW-1:0] rd;
        logic ok;
        rq(0, LL, 4'd7, '0, rd, ok);
        rq(1, STORE, 4'd7, 32'h22, rd, ok);
        rq(0, SC, 4'd7, 32'h33, rd, ok);
        chk("R4 SC after foreign store", 32'(ok), 32'd0);
        rq(2, LOAD, 4'd7, '0, rd, ok);
        chk("R4 memory unchanged", rd, 32'h22);
    endtask

    task automatic t_sc_no_resv();
        logic [DW-1:0] rd;
        logic ok;
        rq(3, SC, 4'd8, 32'h44, rd, ok);
        chk("R5 SC without LL", 32'(ok), 32'd0);
        rq(3, LL, 4'd9, '0, rd, ok);
        rq(3, SC, 4'd8, 32'h45, rd, ok);
        chk("R5 SC other address", 32'(ok), 32'd0);
        rq(1, LOAD, 4'd8, '0, rd, ok);
        chk("R5 no write", rd, 32'd0);
    endtask

    task automatic t_sc_clears();
        logic [DW-1:0] rd;
        logic ok;
        rq(2, LL, 4'd10, '0, rd, ok);
        rq(2, SC, 4'd10, 32'h1, rd, ok);
        chk("R6 first SC", 32'(ok), 32'd1);
        rq(2, SC, 4'd10, 32'h2, rd, ok);
        chk("R6 second SC fails", 32'(ok), 32'd0);
        rq(0, LOAD, 4'd10, '0, rd, ok);
        chk("R6 memory", rd, 32'h1);
    endtask

    task automatic t_own_store();
        logic [DW-1:0] rd;
        logic ok;
        rq(1, LL, 4'd11, '0, rd, ok);
        rq(1, STORE, 4'd11, 32'h5, rd, ok);
        rq(1, SC, 4'd11, 32'h6, rd, ok);
        chk("R7 own store clears", 32'(ok), 32'd0);
        rq(0, LOAD, 4'd11, '0, rd, ok);
        chk("R7 memory", rd, 32'h5);
    endtask

    task automatic t_ll_replace();
        logic [DW-1:0] rd;
        logic ok;
        rq(0, LL, 4'd12, '0, rd, ok);
        rq(0, LL, 4'd13, '0, rd, ok);
        rq(0, SC, 4'd12, 32'h77, rd, ok);
        chk("R8 old address dropped", 32'(ok), 32'd0);
        rq(0, LL, 4'd12, '0, rd, ok);
        rq(0, LL, 4'd13, '0, rd, ok);
        rq(0, SC, 4'd13, 32'h88, rd, ok);
        chk("R8 new address held", 32'(ok), 32'd1);
        rq(1, LOAD, 4'd12, '0, rd, ok);
        chk("R8 old word unwritten", rd, 32'd0);
    endtask

    task automatic t_rr();
        int gc [NC];
        int wraps = 0;
        int ones  = 0;
        for (int c = 0; c < NC; c++) begin
            automatic int cc = c;
            fork
                begin
                    logic [DW-1:0] rd;
                    logic ok;
                    do_req(cc, LOAD, 4'd4, '0, rd, ok, gc[cc]);
                end
            join_none
        end
        wait fork;
        for (int c = 0; c < NC; c++) begin
            int diff = gc[(c + 1) % NC] - gc[c];
            if (diff == 1) ones++;
            if (diff == -(NC - 1)) wraps++;
        end
        chk("R9 cyclic steps", 32'(ones), 32'(NC - 1));
        chk("R9 single wrap", 32'(wraps), 32'd1);
    endtask

    task automatic t_race();
        int gc [NC];
        logic okv [NC];
        logic [DW-1:0] rd;
        logic ok;
        int win, lose;
        rq(1, LL, 4'd14, '0, rd, ok);
        rq(2, LL, 4'd14, '0, rd, ok);
        for (int c = 1; c <= 2; c++) begin
            automatic int cc = c;
            fork
                begin
                    logic [DW-1:0] r2;
                    do_req(cc, SC, 4'd14, 32'h100 + cc, r2, okv[cc], gc[cc]);
                end
            join_none
        end
        wait fork;
        win  = (gc[1] < gc[2]) ? 1 : 2;
        lose = 3 - win;
        chk("R10 first SC wins", 32'(okv[win]), 32'd1);
        chk("R10 second SC loses", 32'(okv[lose]), 32'd0);
        rq(0, LOAD, 4'd14, '0, rd, ok);
        chk("R10 winner data", rd, 32'h100 + win);
    endtask

    int in_cs = 0;
    int viol  = 0;

    task automatic worker(input int c);
        logic [DW-1:0] rd;
        logic ok;
        logic [DW-1:0] v;
        for (int k = 0; k < 5; k++) begin
            ok = 1'b0;
            while (!ok) begin
                rq(c, LL, 4'd0, '0, rd, ok);
                ok = 1'b0;
                if (rd == 0) rq(c, SC, 4'd0, 32'd1, rd, ok);
            end
            in_cs++;
            if (in_cs > 1) viol++;
            rq(c, LOAD, 4'd1, '0, v, ok);
            repeat (c + 1) @(negedge clk);
            rq(c, STORE, 4'd1, v + 1, rd, ok);
            in_cs--;
            rq(c, STORE, 4'd0, 32'd0, rd, ok);
        end
        for (int k = 0; k < 5; k++) begin
            ok = 1'b0;
            while (!ok) begin
                rq(c, LL, 4'd2, '0, v, ok);
                rq(c, SC, 4'd2, v + 1, rd, ok);
            end
        end
    endtask

    task automatic t_spin();
        logic [DW-1:0] rd;
        logic ok;
        rq(0, STORE, 4'd0, 32'd0, rd, ok);
        rq(0, STORE, 4'd1, 32'd0, rd, ok);
        rq(0, STORE, 4'd2, 32'd0, rd, ok);
        for (int c = 0; c < NC; c++) begin
            automatic int cc = c;
            fork
                worker(cc);
            join_none
        end
        wait fork;
        chk("R11 exclusion violations", 32'(viol), 32'd0);
        rq(3, LOAD, 4'd1, '0, rd, ok);
        chk("R11 locked counter", rd, 32'(NC * 5));
        rq(3, LOAD, 4'd2, '0, rd, ok);
        chk("R11 LL/SC increments", rd, 32'(NC * 5));
        rq(3, LOAD, 4'd0, '0, rd, ok);
        chk("R11 lock released", rd, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_load_store();
        t_ll_sc_ok();
        t_sc_broken();
        t_sc_no_resv();
        t_sc_clears();
        t_own_store();
        t_ll_replace();
        t_rr();
        t_race();
        t_spin();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule